// File: doc/BRIEF.md
# Burst Capture Writer

This block sits in the memory clock domain of a sampling front end and moves captured sample words from an on-chip FIFO into an external self-refreshing DRAM. The FIFO fills at the converter's word rate. The memory clock runs faster than that, so the writer does not keep pace word by word. It waits until a whole burst of words is buffered. It then asks the memory for access and streams that burst in one piece. After the burst it leaves a fixed quiet interval, during which the memory may refresh itself.

The memory is a ring of sample locations. A start pointer advances by one burst length after each burst. When a burst ends at the last location of memory, the pointer returns to zero. Memory size is a whole number of bursts, so no burst crosses the end. The pointer is exported so that trigger and readout logic can find the newest data. A sticky flag records any sample that was pushed while the FIFO was full.

The DRAM protocol is reduced to three signals: a request, a grant and a refresh-busy indication. The FIFO is seen through its fill level, a first-word-fall-through read port, a push strobe and a full flag.

Top module: `burst_capture_writer`

## Requirements
- R1: While reset is asserted, `mem_req`, `mem_wvalid`, `fifo_rd_en` and `ovf_flag` are 0 and `wr_ptr` is 0.
- R2: `mem_req` rises only after a clock edge at which `fifo_level` was at least BURST_LEN. It stays low while the level is below that.
- R3: A burst starts only after an edge at which `mem_grant` was 1 and `mem_busy` was 0. While idle and `mem_busy` is 1, no request is raised. A grant given during busy does not start a burst.
- R4: A burst is exactly BURST_LEN consecutive cycles with `mem_wvalid` and `fifo_rd_en` both 1. In each of these cycles `mem_wdata` equals `fifo_rd_data`, so words leave in FIFO order.
- R5: `mem_addr` is valid while `mem_req` is 1 and equals `wr_ptr`. `wr_ptr` changes only after a burst, and then advances by BURST_LEN.
- R6: After a burst that starts at MEM_WORDS-BURST_LEN, `wr_ptr` becomes 0. `wr_ptr` never reaches MEM_WORDS.
- R7: After the last beat of a burst, `mem_req` and `mem_wvalid` stay 0 for GAP_CYC cycles, even when a full burst is already buffered.
- R8: `ovf_flag` becomes 1 on the cycle after an edge at which `smp_push` and `fifo_full` were both 1. It then stays 1 until reset. A push alone, or full alone, leaves it at 0.
- R9: Once `mem_req` is raised, it stays 1 until the burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | LVL_W | Words currently held in the sample FIFO |
| fifo_rd_data | input | DATA_W | Head word of the FIFO (fall-through) |
| fifo_rd_en | output | 1 | Pops the head word |
| smp_push | input | 1 | A sample was written into the FIFO this cycle |
| fifo_full | input | 1 | FIFO is full |
| mem_busy | input | 1 | Memory is refreshing |
| mem_grant | input | 1 | Memory accepts the pending request |
| mem_req | output | 1 | Burst request |
| mem_addr | output | ADDR_W | Burst start address |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | DATA_W | Write beat data |
| wr_ptr | output | ADDR_W | Next burst start location |
| ovf_flag | output | 1 | Sticky FIFO overflow indication |

## Verification
The bench builds the block with BURST_LEN=4, MEM_WORDS=12 and GAP_CYC=3. The ring therefore wraps after three bursts, so the return to zero is reached within a handful of bursts. Four-word bursts and a three-cycle gap keep each beat and each quiet cycle checkable one by one. With these values, delayed grants, refresh that overlaps a pending request, and a full burst that waits during the gap all fit in a short run.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2,
    ST_GAP   = 2'd3
  } wr_state_e;
endpackage

// File: rtl/bcw_rst_sync.sv
module bcw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_n_sync = q2;
endmodule

// File: rtl/bcw_sched.sv
// Burst scheduler: idle -> request -> burst -> gap (R2, R3, R4, R7, R9)
module bcw_sched
  import bcw_pkg::*;
#(
  parameter int BURST_LEN = 32,
  parameter int GAP_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_ready,
  input  logic mem_busy,
  input  logic mem_grant,
  output logic req,
  output logic beat,
  output logic done
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int GAP_W  = $clog2(GAP_CYC + 1);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_CYC - 1);

  wr_state_e st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    gap_d  = gap_q;
    case (st_q)
      ST_IDLE: begin
        if (lvl_ready && !mem_busy) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (mem_grant && !mem_busy) begin
          st_d   = ST_BURST;
          beat_d = '0;
        end
      end
      ST_BURST: begin
        if (beat_q == BEAT_LAST) begin
          st_d  = ST_GAP;
          gap_d = '0;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      default: begin
        if (gap_q == GAP_LAST) st_d = ST_IDLE;
        else                   gap_d = gap_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      gap_q  <= gap_d;
    end
  end

  assign req  = (st_q == ST_REQ);
  assign beat = (st_q == ST_BURST);
  assign done = (st_q == ST_BURST) && (beat_q == BEAT_LAST);
endmodule

// File: rtl/bcw_addr.sv
// Ring start pointer, advanced once per burst (R5, R6)
module bcw_addr #(
  parameter int MEM_WORDS = 1 << 24,
  parameter int BURST_LEN = 32,
  parameter int ADDR_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] LAST_BASE = ADDR_W'(MEM_WORDS - BURST_LEN);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(BURST_LEN);

  logic [ADDR_W-1:0] base_q, base_d;

  always_comb begin
    if (base_q == LAST_BASE) base_d = '0;
    else                     base_d = base_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   base_q <= '0;
    else if (adv) base_q <= base_d;
  end

  assign base = base_q;
endmodule

// File: rtl/bcw_ovf.sv
// Sticky overflow capture (R8)
module bcw_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic full,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = flag_q | (push & full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/burst_capture_writer.sv
module burst_capture_writer #(
  parameter int DATA_W    = 8,
  parameter int MEM_WORDS = 1 << 24,
  parameter int BURST_LEN = 32,
  parameter int GAP_CYC   = 4,
  parameter int LVL_W     = 8,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              fifo_rd_en,
  input  logic              smp_push,
  input  logic              fifo_full,
  input  logic              mem_busy,
  input  logic              mem_grant,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wvalid,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              ovf_flag
);
  logic rst_n_s;
  logic lvl_ready;
  logic beat;
  logic done;
  logic [ADDR_W-1:0] base;

  bcw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign lvl_ready = (fifo_level >= LVL_W'(BURST_LEN));

  bcw_sched #(
    .BURST_LEN (BURST_LEN),
    .GAP_CYC   (GAP_CYC)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .lvl_ready (lvl_ready),
    .mem_busy  (mem_busy),
    .mem_grant (mem_grant),
    .req       (mem_req),
    .beat      (beat),
    .done      (done)
  );

  bcw_addr #(
    .MEM_WORDS (MEM_WORDS),
    .BURST_LEN (BURST_LEN),
    .ADDR_W    (ADDR_W)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (done),
    .base  (base)
  );

  bcw_ovf u_ovf (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (smp_push),
    .full  (fifo_full),
    .flag  (ovf_flag)
  );

  assign fifo_rd_en = beat;
  assign mem_wvalid = beat;
  assign mem_wdata  = fifo_rd_data;
  assign mem_addr   = base;
  assign wr_ptr     = base;
endmodule

// File: rtl/bcw_checker.sv
module bcw_checker #(
  parameter int MEM_WORDS = 1 << 24,
  parameter int BURST_LEN = 32,
  parameter int LVL_W     = 8,
  parameter int ADDR_W    = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              fifo_rd_en,
  input logic              smp_push,
  input logic              fifo_full,
  input logic              mem_busy,
  input logic              mem_grant,
  input logic              mem_req,
  input logic              mem_wvalid,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              ovf_flag
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (mem_wvalid) run_q <= run_q + 16'd1;
    else                 run_q <= '0;
  end

  a_r2_level_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ($past(fifo_level) >= LVL_W'(BURST_LEN)));

  a_r3_no_start_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_busy) |=> !mem_wvalid);

  a_r4_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wvalid) |-> (run_q == 16'(BURST_LEN)));

  a_r4_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (fifo_level != '0));

  a_r5_ptr_moves_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_ptr) |-> $past(mem_wvalid));

  a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= ADDR_W'(MEM_WORDS - 1));

  a_r7_quiet_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wvalid) |-> (!mem_req && !mem_wvalid));

  a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_push && fifo_full) |=> ovf_flag);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !(mem_grant && !mem_busy)) |=> mem_req);
endmodule

bind burst_capture_writer bcw_checker #(
  .MEM_WORDS (MEM_WORDS),
  .BURST_LEN (BURST_LEN),
  .LVL_W     (LVL_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_level (fifo_level),
  .fifo_rd_en (fifo_rd_en),
  .smp_push   (smp_push),
  .fifo_full  (fifo_full),
  .mem_busy   (mem_busy),
  .mem_grant  (mem_grant),
  .mem_req    (mem_req),
  .mem_wvalid (mem_wvalid),
  .wr_ptr     (wr_ptr),
  .ovf_flag   (ovf_flag)
);

// File: tb/burst_capture_writer_tb.sv
module burst_capture_writer_tb;
  localparam int DW  = 8;
  localparam int MW  = 12;
  localparam int BL  = 4;
  localparam int GC  = 3;
  localparam int LW  = 8;
  localparam int AW  = $clog2(MW);

  typedef struct packed {
    int add_n;
    int gdly;
    int busy_n;
    int exp_addr;
    int exp_ptr;
  } row_t;

  localparam row_t ROWS [4] = '{
    '{4, 0, 0, 0, 4},
    '{4, 2, 0, 4, 8},
    '{4, 1, 2, 8, 0},
    '{4, 0, 1, 0, 4}
  };

  logic          clk;
  logic          rst_n;
  logic [LW-1:0] fifo_level;
  logic [DW-1:0] fifo_rd_data;
  logic          fifo_rd_en;
  logic          smp_push;
  logic          fifo_full;
  logic          mem_busy;
  logic          mem_grant;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_wvalid;
  logic [DW-1:0] mem_wdata;
  logic [AW-1:0] wr_ptr;
  logic          ovf_flag;

  int checks;
  int fails;
  int added;
  int popped;
  int exp_idx;

  burst_capture_writer #(
    .DATA_W    (DW),
    .MEM_WORDS (MW),
    .BURST_LEN (BL),
    .GAP_CYC   (GC),
    .LVL_W     (LW)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_level   (fifo_level),
    .fifo_rd_data (fifo_rd_data),
    .fifo_rd_en   (fifo_rd_en),
    .smp_push     (smp_push),
    .fifo_full    (fifo_full),
    .mem_busy     (mem_busy),
    .mem_grant    (mem_grant),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_wvalid   (mem_wvalid),
    .mem_wdata    (mem_wdata),
    .wr_ptr       (wr_ptr),
    .ovf_flag     (ovf_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // FIFO model: words are numbered; head word value is its index XOR A5
  initial popped = 0;
  always @(posedge clk) if (fifo_rd_en) popped <= popped + 1;
  assign fifo_level   = LW'(added - popped);
  assign fifo_rd_data = DW'(popped) ^ 8'hA5;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check_reset_state();
    chk(!mem_req && !mem_wvalid && !fifo_rd_en, "R1 control", {mem_req, mem_wvalid, fifo_rd_en}, 0);
    chk(wr_ptr == '0, "R1 wr_ptr", int'(wr_ptr), 0);
    chk(!ovf_flag, "R1 ovf_flag", int'(ovf_flag), 0);
  endtask

  task automatic do_row(input row_t r);
    int n;
    added += r.add_n;
    n = 0;
    while (!mem_req && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(mem_req, "R2 request raised", int'(mem_req), 1);
    chk(int'(mem_addr) == r.exp_addr, "R5 mem_addr", int'(mem_addr), r.exp_addr);
    for (int i = 0; i < r.gdly; i++) begin
      @(negedge clk);
      chk(mem_req && !mem_wvalid, "R9 request held", int'(mem_req), 1);
    end
    mem_grant = 1'b1;
    mem_busy  = (r.busy_n > 0);
    for (int i = 0; i < r.busy_n; i++) begin
      @(negedge clk);
      chk(mem_req && !mem_wvalid, "R3 grant during refresh", int'(mem_wvalid), 0);
    end
    mem_busy = 1'b0;
    for (int k = 0; k < BL; k++) begin
      @(negedge clk);
      mem_grant = 1'b0;
      chk(mem_wvalid && fifo_rd_en, "R4 beat valid", {mem_wvalid, fifo_rd_en}, 3);
      chk(mem_wdata == (DW'(exp_idx) ^ 8'hA5), "R4 beat data", int'(mem_wdata),
          int'(DW'(exp_idx) ^ 8'hA5));
      exp_idx++;
    end
    for (int g = 0; g < GC; g++) begin
      @(negedge clk);
      chk(!mem_req && !mem_wvalid, "R7 quiet gap", {mem_req, mem_wvalid}, 0);
      if (g == 0) begin
        if (r.exp_ptr == 0)
          chk(int'(wr_ptr) == r.exp_ptr, "R6 wrap", int'(wr_ptr), r.exp_ptr);
        else
          chk(int'(wr_ptr) == r.exp_ptr, "R5 advance", int'(wr_ptr), r.exp_ptr);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    checks    = 0;
    fails     = 0;
    added     = 0;
    exp_idx   = 0;
    rst_n     = 1'b0;
    smp_push  = 1'b0;
    fifo_full = 1'b0;
    mem_busy  = 1'b0;
    mem_grant = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: one word short of a burst gives no request
    added = BL - 1;
    repeat (8) begin
      @(negedge clk);
      chk(!mem_req, "R2 below burst size", int'(mem_req), 0);
    end

    // R3: full burst buffered but refresh active: no request
    mem_busy = 1'b1;
    added    = added + 1;
    repeat (6) begin
      @(negedge clk);
      chk(!mem_req, "R3 idle during refresh", int'(mem_req), 0);
    end
    mem_busy = 1'b0;
    @(negedge clk);
    chk(mem_req, "R2 request after refresh", int'(mem_req), 1);

    // Table-driven bursts: grant delays, refresh overlap, wrap
    foreach (ROWS[i]) do_row(ROWS[i]);

    // R8: overflow flag
    fifo_full = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!ovf_flag, "R8 full alone", int'(ovf_flag), 0);
    end
    fifo_full = 1'b0;
    smp_push  = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!ovf_flag, "R8 push alone", int'(ovf_flag), 0);
    end
    fifo_full = 1'b1;
    @(negedge clk);
    smp_push  = 1'b0;
    fifo_full = 1'b0;
    chk(ovf_flag, "R8 set", int'(ovf_flag), 1);
    repeat (3) begin
      @(negedge clk);
      chk(ovf_flag, "R8 sticky", int'(ovf_flag), 1);
    end

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    finish_run();
  end
endmodule